// File: doc/BRIEF.md
# Cycle-Stealing DMA Transfer Engine

A single-channel DMA engine that copies a programmed number of words from a source address to a destination address over a shared bus. The engine drives both addresses during each data cycle, and the data moves fly-by. Software writes the channel configuration through a write-only register port. It then sets the enable bit. The engine asks for the bus, waits for the grant, and runs an address phase and one data cycle per word. It then gives the bus back with a release cycle.

Each grant carries a fixed overhead: two arbitration cycles, one address cycle and one release cycle. The transfer mode decides how many words share that overhead. Single mode moves one word, or one short burst, per grant. Block mode keeps the bus until the count runs out. Demand mode keeps the bus only while the device request stays high. When the count reaches zero the channel disables itself and can raise a sticky interrupt.

Top module: `cs_dma_engine`

## Requirements
- R1: Register select 0 is control, 1 is source, 2 is destination, 3 is word count and 4 is mode. Writes to selects 1 to 4 are ignored while the channel is enabled. The control register is always writable.
- R2: In single mode with burst code 00, every grant moves exactly one word. The grant takes exactly five cycles: two with bus_req_o high before the address phase, one address-phase cycle, one data cycle and one release cycle.
- R3: In single mode, mode bits [5:4] select the words per grant: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. The bus is released between grants.
- R4: When fewer words remain than the burst length, the final grant moves only the remaining words.
- R5: Block mode (mode bits [7:6] = 10) moves the whole count in one grant. bus_req_o is high for count+3 cycles, followed by one release cycle.
- R6: Demand mode (mode bits [7:6] = 00) requests the bus only while dreq_i is high. A data cycle with dreq_i low moves no word and ends the grant.
- R7: Cascade mode (mode bits [7:6] = 11), or a word count of zero, never raises bus_req_o.
- R8: src_addr_o holds the source address for every word. dst_addr_o steps by one after each word when mode bit 0 is 1, and stays fixed when mode bit 0 is 0.
- R9: Control bit 1 enables the interrupt. When the last word moves, the channel enable clears, and irq_o sets if the interrupt is enabled. irq_o stays set until a control write with bit 2 = 1. A completion in the same cycle as that write wins.
- R10: A control write with bit 0 = 0 stops the channel. No word moves in a cycle after that write, and the bus is released. Setting bit 0 again resumes with the remaining count and the current destination.
- R11: While bus_gnt_i is low, bus_req_o stays high and no address phase or word transfer occurs.
- R12: After reset, bus_req_o, xfer_o and irq_o are low and every register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | DW | Register write data |
| dreq_i | input | 1 | Device request, used in demand mode |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| bus_req_o | output | 1 | Bus request, high from arbitration to the last data cycle |
| addr_phase_o | output | 1 | Address-phase cycle |
| xfer_o | output | 1 | A word moves in this cycle |
| rel_o | output | 1 | Release cycle |
| src_addr_o | output | AW | Source address of the current word |
| dst_addr_o | output | AW | Destination address of the current word |
| irq_o | output | 1 | Sticky completion interrupt |

## Verification
Two events can fall in the same cycle: completion setting the interrupt, and a software write-1-to-clear of that interrupt. The bench counts data cycles at the ports. In the cycle that carries the last word, it drives a control write with the clear bit set, so the write lands on the same edge as completion. irq_o must read 1 afterwards, and a later clear with no completion must bring it to 0.

Stopping the channel also meets the transfer in flight: a disable write lands while a block grant is moving words. That case is judged by three things: no word moves after the write, the bus is released, and the count resumes correctly on re-enable.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

  typedef enum logic [1:0] {
    XM_DEMAND  = 2'b00,
    XM_SINGLE  = 2'b01,
    XM_BLOCK   = 2'b10,
    XM_CASCADE = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB1,
    ST_ARB2,
    ST_ADDR,
    ST_DATA,
    ST_REL
  } seq_state_e;

  typedef struct packed {
    xfer_mode_e  mode;
    logic [1:0]  burst;
    logic        dst_inc;
  } mode_cfg_t;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_SRC  = 3'd1;
  localparam logic [2:0] SEL_DST  = 3'd2;
  localparam logic [2:0] SEL_CNT  = 3'd3;
  localparam logic [2:0] SEL_MODE = 3'd4;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_IRQEN = 1;
  localparam int CTRL_CLR   = 2;

endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
  import cs_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          xfer_i,
  output logic          en_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output mode_cfg_t     mode_o,
  output logic          irq_o
);

  logic          en_q, irq_en_q, irq_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  mode_cfg_t     mode_q;
  logic          ctrl_wr, cfg_ok, last_word;
  logic          unused_wdata;

  assign ctrl_wr      = we_i && (sel_i == SEL_CTRL);
  assign cfg_ok       = we_i && !en_q;
  assign last_word    = xfer_i && (cnt_q == CW'(1));
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      irq_q    <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      mode_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q     <= wdata_i[CTRL_EN];
        irq_en_q <= wdata_i[CTRL_IRQEN];
      end
      if (last_word) en_q <= 1'b0;
      // completion beats a same-cycle clear
      if (last_word && irq_en_q)            irq_q <= 1'b1;
      else if (ctrl_wr && wdata_i[CTRL_CLR]) irq_q <= 1'b0;
      if (cfg_ok && sel_i == SEL_SRC) src_q <= wdata_i[AW-1:0];
      if (xfer_i && mode_q.dst_inc)         dst_q <= dst_q + AW'(1);
      else if (cfg_ok && sel_i == SEL_DST)  dst_q <= wdata_i[AW-1:0];
      if (xfer_i)                           cnt_q <= cnt_q - CW'(1);
      else if (cfg_ok && sel_i == SEL_CNT)  cnt_q <= wdata_i[CW-1:0];
      if (cfg_ok && sel_i == SEL_MODE) begin
        mode_q.mode    <= xfer_mode_e'(wdata_i[7:6]);
        mode_q.burst   <= wdata_i[5:4];
        mode_q.dst_inc <= wdata_i[0];
      end
    end
  end

  assign en_o   = en_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign irq_o  = irq_q;

  AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && we_i && sel_i == SEL_DST && !xfer_i) |=> $stable(dst_q)); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> (cnt_q == ($past(cnt_q) - CW'(1)))); // R5
  AST_DST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && mode_q.dst_inc) |=> (dst_q == ($past(dst_q) + AW'(1)))); // R8
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && cnt_q == CW'(1) && irq_en_q) |=> irq_q); // R9
  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && cnt_q == CW'(1)) |=> !en_q); // R9

endmodule

// File: rtl/cs_dma_grant_len.sv
module cs_dma_grant_len
  import cs_dma_pkg::*;
#(
  parameter int CW = 16
) (
  input  xfer_mode_e    mode_i,
  input  logic [1:0]    burst_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] len_o
);

  localparam int BW = 5;

  logic [BW-1:0] burst_words;
  logic [CW-1:0] burst_ext;

  // 00 -> 1, 01 -> 4, 10 -> 8, 11 -> 16
  assign burst_words = (burst_i == 2'b00) ? BW'(1) : (BW'(2) << burst_i);
  assign burst_ext   = CW'(burst_words);

  always_comb begin
    if (mode_i == XM_SINGLE && cnt_i > burst_ext) len_o = burst_ext;
    else                                          len_o = cnt_i;
  end

endmodule

// File: rtl/cs_dma_seq.sv
module cs_dma_seq
  import cs_dma_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  xfer_mode_e    mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] grant_len_i,
  input  logic          dreq_i,
  input  logic          gnt_i,
  output logic          bus_req_o,
  output logic          addr_phase_o,
  output logic          xfer_o,
  output logic          rel_o
);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] beat_q;
  logic          start_ok, want;

  always_comb begin
    unique case (mode_i)
      XM_DEMAND:          start_ok = dreq_i;
      XM_SINGLE, XM_BLOCK: start_ok = 1'b1;
      default:            start_ok = 1'b0;
    endcase
  end

  assign want   = en_i && (cnt_i != '0) && start_ok;
  assign xfer_o = (state_q == ST_DATA) && en_i && ((mode_i != XM_DEMAND) || dreq_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (want) state_d = ST_ARB1;
      ST_ARB1: if (gnt_i) state_d = ST_ARB2;
      ST_ARB2: state_d = gnt_i ? ST_ADDR : ST_ARB1;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: if (!xfer_o || beat_q == CW'(1)) state_d = ST_REL;
      ST_REL:  state_d = want ? ST_ARB1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ADDR) beat_q <= grant_len_i;
      else if (xfer_o)        beat_q <= beat_q - CW'(1);
    end
  end

  assign bus_req_o    = (state_q == ST_ARB1) || (state_q == ST_ARB2) ||
                        (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign addr_phase_o = (state_q == ST_ADDR);
  assign rel_o        = (state_q == ST_REL);

  AST_BEAT_LE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (beat_q <= cnt_i)); // R4
  AST_BURST_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && mode_i == XM_SINGLE) |-> (beat_q <= CW'(16))); // R3
  AST_DEMAND_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && mode_i == XM_DEMAND && !dreq_i) |=> (state_q == ST_REL)); // R6
  AST_GNT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARB1 && !gnt_i) |=> (state_q == ST_ARB1)); // R11
  AST_CASCADE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && mode_i == XM_CASCADE) |=> !bus_req_o); // R7

endmodule

// File: rtl/cs_dma_engine.sv
module cs_dma_engine
  import cs_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          dreq_i,
  input  logic          bus_gnt_i,
  output logic          bus_req_o,
  output logic          addr_phase_o,
  output logic          xfer_o,
  output logic          rel_o,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          irq_o
);

  logic          en;
  logic [CW-1:0] cnt, grant_len;
  mode_cfg_t     mode_cfg;
  logic          xfer;

  cs_dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .xfer_i  (xfer),
    .en_o    (en),
    .src_o   (src_addr_o),
    .dst_o   (dst_addr_o),
    .cnt_o   (cnt),
    .mode_o  (mode_cfg),
    .irq_o   (irq_o)
  );

  cs_dma_grant_len #(.CW(CW)) u_grant_len (
    .mode_i  (mode_cfg.mode),
    .burst_i (mode_cfg.burst),
    .cnt_i   (cnt),
    .len_o   (grant_len)
  );

  cs_dma_seq #(.CW(CW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .mode_i       (mode_cfg.mode),
    .cnt_i        (cnt),
    .grant_len_i  (grant_len),
    .dreq_i       (dreq_i),
    .gnt_i        (bus_gnt_i),
    .bus_req_o    (bus_req_o),
    .addr_phase_o (addr_phase_o),
    .xfer_o       (xfer),
    .rel_o        (rel_o)
  );

  assign xfer_o = xfer;

endmodule

// File: tb/cs_dma_engine_bench.sv
`timescale 1ns/100ps
module cs_dma_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dreq = 1'b0;
  logic        gnt = 1'b1;
  logic        bus_req, addr_phase, xfer, rel, irq;
  logic [15:0] src_addr, dst_addr;

  always #2 clk = ~clk;

  cs_dma_engine u_cs_dma_engine (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .dreq_i(dreq), .bus_gnt_i(gnt),
    .bus_req_o(bus_req), .addr_phase_o(addr_phase), .xfer_o(xfer),
    .rel_o(rel), .src_addr_o(src_addr), .dst_addr_o(dst_addr), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expectations shared with the monitor
  int          exp_rem, exp_bl;
  bit          exp_blk, exp_inc, chk_len;
  logic [15:0] exp_src, exp_dst;
  int mon_words, mon_grants, mon_req_total, mon_addr_total;
  bit in_grant, prev_rel;
  int g_rem, req_cyc, gw, gaddr;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // port monitor, samples half a nanosecond after each falling edge
  always begin
    @(negedge clk);
    #0.5;
    if (rst_n) begin
      if (bus_req && !in_grant) begin
        in_grant = 1; g_rem = exp_rem; req_cyc = 0; gw = 0; gaddr = 0;
      end
      if (bus_req) begin req_cyc++; mon_req_total++; end
      if (addr_phase) begin gaddr++; mon_addr_total++; end
      if (xfer) begin
        chk(src_addr == exp_src, "R8 src", src_addr, exp_src);
        chk(dst_addr == exp_dst, "R8 dst", dst_addr, exp_dst);
        if (exp_inc) exp_dst = exp_dst + 16'd1;
        exp_rem--; gw++; mon_words++;
      end
      if (rel) begin
        chk(!prev_rel, "R2 single release cycle", 2, 1);
        if (in_grant) begin
          in_grant = 0; mon_grants++;
          if (chk_len) begin
            int ew;
            ew = (exp_blk || g_rem < exp_bl) ? g_rem : exp_bl;
            chk(gw == ew, exp_blk ? "R5 words" : (g_rem < exp_bl ? "R4 words" : "R3 words"), gw, ew);
            chk(req_cyc == 3 + gw, exp_blk ? "R5 cycles" : "R2 cycles", req_cyc, 3 + gw);
            chk(gaddr == 1, "R2 address phase", gaddr, 1);
          end
        end
      end
      prev_rel = rel;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim && !irq; i++) begin
      @(negedge clk); #1;
    end
    settle(1);
  endtask

  function automatic int burst_words(input int bc);
    return (bc == 0) ? 1 : (2 << bc);
  endfunction

  task automatic setup(input int md, input int bc, input int cnt, input int inc, input int ctrl);
    exp_src = 16'h1000 + 16'(cnt * 3 + md);
    exp_dst = 16'h8000 + 16'(cnt * 5 + bc);
    exp_rem = cnt; exp_inc = inc[0]; exp_blk = (md == 2);
    exp_bl = burst_words(bc); chk_len = 1;
    mon_words = 0; mon_grants = 0; mon_req_total = 0; mon_addr_total = 0;
    wr(3'd1, 32'(exp_src));
    wr(3'd2, 32'(exp_dst));
    wr(3'd3, 32'(cnt));
    wr(3'd4, 32'((md << 6) | (bc << 4) | inc));
    wr(3'd0, 32'(ctrl));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int w1, seen;
    settle(3);
    rst_n = 1'b1;
    settle(2);
    // R12 reset state
    chk(bus_req == 0, "R12 bus_req", bus_req, 0);
    chk(xfer == 0, "R12 xfer", xfer, 0);
    chk(irq == 0, "R12 irq", irq, 0);
    chk(dst_addr == 0, "R12 dst", dst_addr, 0);

    // R2 R3 R4 R5 R8 R9 sweep over mode, burst, count, increment
    for (int md = 1; md <= 2; md++)
      for (int bc = 0; bc < 4; bc++) begin
        if (md == 2 && bc != 0) continue;
        for (int cnt = 1; cnt <= 18; cnt++)
          for (int inc = 0; inc < 2; inc++) begin
            int eg;
            setup(md, bc, cnt, inc, 3);
            wait_irq(40 * cnt + 60);
            eg = (md == 2) ? 1 : (cnt + burst_words(bc) - 1) / burst_words(bc);
            chk(irq == 1, "R9 irq on completion", irq, 1);
            chk(mon_words == cnt, "R5 word total", mon_words, cnt);
            chk(mon_grants == eg, md == 2 ? "R5 grants" : "R3 grants", mon_grants, eg);
            chk(bus_req == 0, "R2 bus released", bus_req, 0);
            wr(3'd0, 32'h4);
            settle(1);
            chk(irq == 0, "R9 irq clear", irq, 0);
          end
      end

    // R1 config writes while enabled are ignored
    setup(1, 1, 6, 1, 3);
    wr(3'd2, 32'h999);
    wr(3'd3, 32'd100);
    wr(3'd4, 32'h80);
    wait_irq(200);
    chk(mon_words == 6, "R1 count locked", mon_words, 6);
    chk(mon_grants == 2, "R1 mode locked", mon_grants, 2);
    wr(3'd0, 32'h4);

    // R7 cascade and zero count
    setup(3, 0, 5, 1, 3);
    settle(20);
    chk(mon_req_total == 0, "R7 cascade quiet", mon_req_total, 0);
    wr(3'd0, 32'h0);
    setup(1, 0, 0, 1, 3);
    settle(20);
    chk(mon_req_total == 0, "R7 zero count quiet", mon_req_total, 0);
    wr(3'd0, 32'h0);

    // R11 grant wait
    gnt = 1'b0;
    setup(1, 0, 2, 1, 3);
    chk_len = 0;
    settle(10);
    chk(bus_req == 1, "R11 request held", bus_req, 1);
    chk(mon_addr_total == 0, "R11 no address phase", mon_addr_total, 0);
    chk(mon_words == 0, "R11 no transfer", mon_words, 0);
    gnt = 1'b1;
    wait_irq(100);
    chk(mon_words == 2, "R11 after grant", mon_words, 2);
    wr(3'd0, 32'h4);

    // R6 demand mode
    setup(0, 0, 12, 1, 3);
    chk_len = 0;
    settle(10);
    chk(mon_req_total == 0, "R6 no request without dreq", mon_req_total, 0);
    dreq = 1'b1;
    repeat (8) @(negedge clk);
    dreq = 1'b0;
    settle(10);
    w1 = mon_words;
    chk(w1 > 0 && w1 < 12, "R6 partial words", w1, 6);
    chk(bus_req == 0, "R6 released on drop", bus_req, 0);
    settle(10);
    chk(mon_words == w1, "R6 hold while low", mon_words, w1);
    dreq = 1'b1;
    wait_irq(200);
    chk(mon_words == 12, "R6 total", mon_words, 12);
    dreq = 1'b0;
    wr(3'd0, 32'h4);

    // R10 disable mid block, then resume
    setup(2, 0, 40, 1, 3);
    chk_len = 0;
    for (int i = 0; i < 200 && mon_words < 10; i++) settle(1);
    wr(3'd0, 32'h0);
    settle(5);
    w1 = mon_words;
    chk(w1 < 40, "R10 stopped early", w1, 39);
    settle(20);
    chk(mon_words == w1, "R10 no words after disable", mon_words, w1);
    chk(bus_req == 0, "R10 bus released", bus_req, 0);
    chk(irq == 0, "R10 no irq", irq, 0);
    chk_len = 1;
    wr(3'd0, 32'h3);
    wait_irq(200);
    chk(mon_words == 40, "R10 resume total", mon_words, 40);
    chk(mon_grants == 2, "R10 grants", mon_grants, 2);
    wr(3'd0, 32'h4);

    // R9 no interrupt when disabled in control
    setup(1, 0, 2, 1, 1);
    settle(30);
    chk(irq == 0, "R9 irq masked", irq, 0);
    chk(mon_words == 2, "R9 masked words", mon_words, 2);

    // R9 completion and clear in the same cycle
    setup(1, 0, 3, 1, 3);
    seen = 0;
    for (int i = 0; i < 200 && seen < 3; i++) begin
      @(negedge clk); #1;
      if (xfer) seen++;
      if (seen == 2 && !xfer) chk(irq == 0, "R9 irq before last", irq, 0);
    end
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h6;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk(irq == 1, "R9 set wins over clear", irq, 1);
    wr(3'd0, 32'h4);
    settle(1);
    chk(irq == 0, "R9 clear alone", irq, 0);

    finish_up();
  end

endmodule